// File: doc/BRIEF.md
# Triggered Channel Event Latch

This block watches a write bus on behalf of eight auto-triggered DMA channels. Each channel has its own programmed trigger address and an enable bit. A bus write that lands on a channel's trigger address, with at least one byte lane active, latches that channel's pending-event bit. Pending events go to a transfer-submission stage one at a time over a valid/ready handshake. The lowest-numbered pending channel is always offered first. An accepted event clears its bit.

Software can drop pending events through a write-one-to-clear port. A trigger can arrive for a channel whose bit is still pending. In that case the block does not merge it away silently. It records it in a separate sticky missed-event vector, which software clears through its own write-one-to-clear port. Both vectors can be read as 32-bit words. The channel bits sit in the low byte and the rest read as zero.

Top module: `evl_event_latch`

## Requirements
- R1: After reset the pending vector and the missed vector are all zeros, and `sub_valid` is low.
- R2: Take a cycle with `wr_valid` high, `wr_addr` equal to an enabled channel's trigger address and `wr_be` non-zero. After the next clock edge that channel's pending bit is set. A write with `wr_be` all zero, or to an address that matches no channel, changes nothing.
- R3: A matching write to a channel whose `chan_en` bit is low does not set its pending bit and never sets its missed bit.
- R4: `sub_valid` is high exactly when some pending bit is set. `sub_chan` then carries the index of the lowest-numbered pending channel.
- R5: A cycle with `sub_valid` and `sub_ready` both high clears the offered channel's pending bit at that clock edge. While `sub_ready` is low, the pending vector holds.
- R6: In a cycle with `clr_valid` high, every channel whose `clr_mask` bit is 1 has its pending bit cleared. Mask bits of 0, or any mask while `clr_valid` is low, have no effect.
- R7: A trigger and a removal (software clear or submit acceptance) for the same channel in the same cycle leave the pending bit set.
- R8: A trigger to an enabled channel whose pending bit is already set, and is not being removed in that cycle, sets that channel's missed bit.
- R9: Missed bits are sticky. Only a cycle with `mclr_valid` high and the matching `mclr_mask` bit set clears one. A new miss in that same cycle wins and keeps the bit set.
- R10: `evt_rd` carries the pending vector in bits 7:0, with channel n at bit n. `miss_rd` carries the missed vector in the same layout. Bits 31:8 of both read as zero.
- R11: When several channels share a trigger address, one matching write sets the pending bit of every enabled channel among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Monitored bus write is present |
| wr_addr | input | 32 | Monitored write address |
| wr_be | input | 4 | Monitored write byte enables |
| chan_addr | input | 256 | Trigger address per channel, channel n in bits [32n+31:32n] |
| chan_en | input | 8 | Per-channel trigger enable |
| clr_valid | input | 1 | Software pending-clear strobe |
| clr_mask | input | 8 | Channels whose pending bit is cleared |
| mclr_valid | input | 1 | Software missed-clear strobe |
| mclr_mask | input | 8 | Channels whose missed bit is cleared |
| sub_valid | output | 1 | An event is offered for submission |
| sub_chan | output | 3 | Channel index of the offered event |
| sub_ready | input | 1 | Submission stage accepts the offered event |
| evt_rd | output | 32 | Pending vector read word |
| miss_rd | output | 32 | Missed vector read word |

## Verification
Suppose a channel's pending flop goes wrong. The error reaches `evt_rd` one edge after the write or clear that caused it. If that channel is the lowest pending one, `sub_valid` and `sub_chan` show it in the same cycle. A bad priority pick shows straight away as the wrong `sub_chan`. It then also shows one edge later as the wrong bit clearing on acceptance. A missed bit that was lost or set by mistake shows only on `miss_rd`. It stays wrong there until a missed-clear, so the bench reads `miss_rd` both after each retrigger and after unrelated pending clears.

// File: rtl/evl_pkg.sv
package evl_pkg;

  localparam int unsigned EVL_MAX_CH = 32;

  // Index of the lowest set bit, zero when the vector is empty.
  function automatic int unsigned first_set(input logic [EVL_MAX_CH-1:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = EVL_MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Mask of all bit positions strictly below idx.
  function automatic logic [EVL_MAX_CH-1:0] below_mask(input int unsigned idx);
    logic [EVL_MAX_CH-1:0] m;
    m = '0;
    for (int i = 0; i < EVL_MAX_CH; i++) begin
      if (i < int'(idx)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/evl_match.sv
module evl_match #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int BEW = 4
) (
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BEW-1:0]   wr_be,
  input  logic [NCH*AW-1:0] chan_addr,
  output logic [NCH-1:0]   hit
);

  logic lane_active;
  assign lane_active = wr_valid && (wr_be != '0);

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    logic [AW-1:0] target;
    assign target = chan_addr[g*AW +: AW];
    assign hit[g] = lane_active && (wr_addr == target);
  end

endmodule

// File: rtl/evl_pick.sv
module evl_pick
  import evl_pkg::*;
#(
  parameter int NCH = 8,
  parameter int IW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic           valid,
  output logic [IW-1:0]  idx
);

  logic [EVL_MAX_CH-1:0] req_wide;
  assign req_wide = EVL_MAX_CH'(req);
  assign valid    = (req != '0);
  assign idx      = IW'(first_set(req_wide));

  // R4: the offered index is pending and nothing below it is
  p_pick_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (req_wide[idx] && ((req_wide & below_mask(32'(idx))) == '0)));

endmodule

// File: rtl/evl_cell.sv
module evl_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic drop,
  input  logic mclr,
  output logic evt,
  output logic miss
);

  logic miss_set;
  assign miss_set = trig && evt && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt  <= 1'b0;
      miss <= 1'b0;
    end else begin
      evt  <= trig || (evt && !drop);
      miss <= miss_set || (miss && !mclr);
    end
  end

  // R2 / R7: a trigger always leaves the bit set
  p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> evt);

  // R8: retrigger of a pending, non-dropped channel records a miss
  p_missed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && evt && !drop) |=> miss);

  // R9: a missed bit survives any cycle without a missed-clear
  p_miss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !mclr) |=> miss);

endmodule

// File: rtl/evl_event_latch.sv
module evl_event_latch #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int BEW = 4,
  parameter int RDW = 32,
  parameter int IW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BEW-1:0]    wr_be,
  input  logic [NCH*AW-1:0] chan_addr,
  input  logic [NCH-1:0]    chan_en,
  input  logic              clr_valid,
  input  logic [NCH-1:0]    clr_mask,
  input  logic              mclr_valid,
  input  logic [NCH-1:0]    mclr_mask,
  output logic              sub_valid,
  output logic [IW-1:0]     sub_chan,
  input  logic              sub_ready,
  output logic [RDW-1:0]    evt_rd,
  output logic [RDW-1:0]    miss_rd
);

  logic [NCH-1:0] hit_v;
  logic [NCH-1:0] trig_v;
  logic [NCH-1:0] clr_v;
  logic [NCH-1:0] svc_v;
  logic [NCH-1:0] drop_v;
  logic [NCH-1:0] mclr_v;
  logic [NCH-1:0] evt_v;
  logic [NCH-1:0] miss_v;
  logic           sub_fire;

  evl_match #(.NCH(NCH), .AW(AW), .BEW(BEW)) u_match (
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_be     (wr_be),
    .chan_addr (chan_addr),
    .hit       (hit_v)
  );

  evl_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (evt_v),
    .valid (sub_valid),
    .idx   (sub_chan)
  );

  assign trig_v   = hit_v & chan_en;
  assign clr_v    = clr_valid ? clr_mask : '0;
  assign mclr_v   = mclr_valid ? mclr_mask : '0;
  assign sub_fire = sub_valid && sub_ready;
  assign svc_v    = sub_fire ? (NCH'(1) << sub_chan) : '0;
  assign drop_v   = clr_v | svc_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evl_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (trig_v[g]),
      .drop  (drop_v[g]),
      .mclr  (mclr_v[g]),
      .evt   (evt_v[g]),
      .miss  (miss_v[g])
    );
  end

  assign evt_rd  = RDW'(evt_v);
  assign miss_rd = RDW'(miss_v);

  // R5: an accepted, non-retriggered event is gone after the edge
  p_fire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_fire && !trig_v[sub_chan]) |=> !evt_v[$past(sub_chan)]);

  // R3: no pending or missed bit rises on a channel that was disabled
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((evt_v & ~$past(evt_v) & ~$past(chan_en)) == '0) &&
              ((miss_v & ~$past(miss_v) & ~$past(chan_en)) == '0)));

endmodule

// File: tb/sim_evl_event_latch.sv
module sim_evl_event_latch;

  localparam int CLK_P = 10;
  localparam int NCH   = 8;
  localparam int AW    = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [3:0]        wr_be = '0;
  logic [NCH*AW-1:0] chan_addr;
  logic [NCH-1:0]    chan_en = '1;
  logic              clr_valid = 1'b0;
  logic [NCH-1:0]    clr_mask = '0;
  logic              mclr_valid = 1'b0;
  logic [NCH-1:0]    mclr_mask = '0;
  logic              sub_valid;
  logic [2:0]        sub_chan;
  logic              sub_ready = 1'b0;
  logic [31:0]       evt_rd;
  logic [31:0]       miss_rd;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  evl_event_latch u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_be(wr_be), .chan_addr(chan_addr), .chan_en(chan_en),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .mclr_valid(mclr_valid),
    .mclr_mask(mclr_mask), .sub_valid(sub_valid), .sub_chan(sub_chan),
    .sub_ready(sub_ready), .evt_rd(evt_rd), .miss_rd(miss_rd)
  );

  function automatic logic [AW-1:0] addr_of(input int ch);
    return 32'h4000_0100 + 32'(ch * 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus, applied at a falling edge; returns at the next falling edge.
  task automatic cyc(input bit w, input logic [AW-1:0] a, input logic [3:0] be,
                     input bit cv, input logic [7:0] cm,
                     input bit mv, input logic [7:0] mm, input bit rdy);
    wr_valid = w; wr_addr = a; wr_be = be;
    clr_valid = cv; clr_mask = cm; mclr_valid = mv; mclr_mask = mm; sub_ready = rdy;
    @(negedge clk);
    wr_valid = 1'b0; wr_be = '0; clr_valid = 1'b0; clr_mask = '0;
    mclr_valid = 1'b0; mclr_mask = '0; sub_ready = 1'b0;
  endtask

  task automatic hit(input int ch);
    cyc(1'b1, addr_of(ch), 4'b0001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic wipe();
    cyc(1'b0, '0, '0, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 evt", evt_rd, 32'h0);
    check("R1 miss", miss_rd, 32'h0);
    check("R1 valid", 32'(sub_valid), 32'h0);
  endtask

  task automatic t_basic();
    cyc(1'b1, addr_of(2), 4'b0010, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    check("R2 set ch2", evt_rd, 32'h04);
    check("R4 valid", 32'(sub_valid), 32'h1);
    check("R4 chan", 32'(sub_chan), 32'h2);
    hit(7);
    check("R10 layout", evt_rd, 32'h84);
    check("R10 upper", 32'(evt_rd[31:8]), 32'h0);
    wipe();
  endtask

  task automatic t_no_lane();
    cyc(1'b1, addr_of(1), 4'b0000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    check("R2 be zero", evt_rd, 32'h0);
    cyc(1'b1, addr_of(1) + 32'h4, 4'b1111, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    check("R2 no match", evt_rd, 32'h0);
  endtask

  task automatic t_disabled();
    chan_en = 8'hEF;
    hit(4);
    check("R3 no set", evt_rd, 32'h0);
    hit(4);
    check("R3 no miss", miss_rd, 32'h0);
    chan_en = 8'hFF;
  endtask

  task automatic t_priority();
    hit(5); hit(3); hit(6);
    check("R4 pick", 32'(sub_chan), 32'h3);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    check("R5 hold", evt_rd, 32'h68);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    check("R5 accept 3", evt_rd, 32'h60);
    check("R4 next", 32'(sub_chan), 32'h5);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    check("R5 accept 5", evt_rd, 32'h40);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    check("R5 empty", evt_rd, 32'h0);
    check("R4 idle", 32'(sub_valid), 32'h0);
    check("R5 no miss", miss_rd, 32'h0);
  endtask

  task automatic t_swclear();
    hit(0); hit(1);
    cyc(1'b0, '0, '0, 1'b1, 8'h02, 1'b0, 8'h00, 1'b0);
    check("R6 clear", evt_rd, 32'h01);
    cyc(1'b0, '0, '0, 1'b0, 8'h01, 1'b0, 8'h00, 1'b0);
    check("R6 no strobe", evt_rd, 32'h01);
  endtask

  task automatic t_collide();
    hit(1);
    cyc(1'b1, addr_of(1), 4'b0100, 1'b1, 8'h02, 1'b0, 8'h00, 1'b0);
    check("R7 clr vs trig", evt_rd, 32'h03);
    check("R7 no miss", miss_rd, 32'h0);
    cyc(1'b1, addr_of(0), 4'b1000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    check("R7 svc vs trig", evt_rd, 32'h03);
    wipe();
  endtask

  task automatic t_missed();
    hit(6); hit(6);
    check("R8 miss", miss_rd, 32'h40);
    check("R8 evt", evt_rd, 32'h40);
    cyc(1'b0, '0, '0, 1'b1, 8'h40, 1'b0, 8'h00, 1'b0);
    check("R9 sticky", miss_rd, 32'h40);
    cyc(1'b0, '0, '0, 1'b0, 8'h00, 1'b1, 8'h40, 1'b0);
    check("R9 clear", miss_rd, 32'h0);
    hit(6);
    cyc(1'b1, addr_of(6), 4'b0001, 1'b0, 8'h00, 1'b1, 8'h40, 1'b0);
    check("R9 set wins", miss_rd, 32'h40);
    wipe();
  endtask

  task automatic t_shared();
    chan_addr[3*AW +: AW] = addr_of(2);
    hit(2);
    check("R11 shared", evt_rd, 32'h0C);
    chan_addr[3*AW +: AW] = addr_of(3);
    wipe();
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chan_addr[i*AW +: AW] = addr_of(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_no_lane();
    t_disabled();
    t_priority();
    t_swclear();
    t_collide();
    t_missed();
    t_shared();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule